// File: doc/BRIEF.md
# Triple Half-Bridge Interlock and Fault Latch

This block sits between the latched command word of a three-leg power stage and the six gate-drive enables. Each leg has one high-side and one low-side switch. Both switches of a leg are never enabled together. A switch that sees a short-circuit, when overcurrent shutdown is armed, or that sees overtemperature is latched off. It stays off until software writes the command again.

The block also keeps sticky summary flags for short-circuit, open-load and supply failure. A status-reset pulse clears these flags. The per-switch status bits are separate: they always show the real state of the gate enables, so software can find which switch was shut down.

The command is captured on a one-cycle load pulse. Undervoltage and the active-low standby input force every gate off in the same cycle. When they go away, the gates return to the latched command.

Top module: `hb_guard`

## Requirements
- R1: After reset, all gate enables, all status bits and all four flags are 0, and the latched command is all-off.
- R2: A one-cycle `cmd_load` captures `cmd_hi`/`cmd_lo`, where bit i belongs to leg i. From the next cycle each gate follows its command when no fault, standby or undervoltage applies.
- R3: If both switches of a leg are commanded on, both gates of that leg are off until a legal command is loaded. The other legs are not affected.
- R4: With `ocs_en` high, a short flag on a conducting switch turns that switch off from the next cycle and sets `flag_sc` in the next cycle. `flag_sc` stays set after the short goes away.
- R5: With `ocs_en` low, a short flag is ignored: the switch stays on and `flag_sc` stays 0.
- R6: An overtemperature flag on a conducting switch turns it off from the next cycle, whatever the value of `ocs_en`. It does not set `flag_sc`.
- R7: A switch turned off by short or overtemperature stays off after the fault flag drops. The next `cmd_load` re-arms it, and it then follows the new command.
- R8: `stat_hi`/`stat_lo` always equal the actual gate enables.
- R9: `flag_ol` is set one cycle after an open-load flag is seen on a conducting switch. An open-load flag on a switch that is off has no effect.
- R10: While `uv` is high, all gates are off in the same cycle, and `flag_psf` is set from the next cycle. When `uv` drops, the gates return to the latched command without a new load.
- R11: While `inh_n` is low, all gates are off in the same cycle. The latched command is kept and comes back when `inh_n` rises.
- R12: `clr_stat` clears `flag_sc`, `flag_ol` and `flag_psf` in the next cycle. It does not change the status bits or `flag_tp`. A set event in the same cycle wins over the clear.
- R13: `flag_tp` shows `prewarn` delayed by one cycle and is not sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Pulse that latches a new command |
| cmd_hi | input | NLEG | Commanded high-side states |
| cmd_lo | input | NLEG | Commanded low-side states |
| ocs_en | input | 1 | Overcurrent shutdown armed |
| clr_stat | input | 1 | Clear the sticky summary flags |
| sc_hi | input | NLEG | Short-circuit seen on high-side switches |
| sc_lo | input | NLEG | Short-circuit seen on low-side switches |
| ol_hi | input | NLEG | Open-load seen on high-side switches |
| ol_lo | input | NLEG | Open-load seen on low-side switches |
| ot_hi | input | NLEG | Overtemperature on high-side switches |
| ot_lo | input | NLEG | Overtemperature on low-side switches |
| prewarn | input | 1 | Temperature prewarning |
| uv | input | 1 | Supply undervoltage |
| inh_n | input | 1 | Standby when low |
| gate_hi | output | NLEG | High-side gate enables |
| gate_lo | output | NLEG | Low-side gate enables |
| stat_hi | output | NLEG | Real high-side state |
| stat_lo | output | NLEG | Real low-side state |
| flag_sc | output | 1 | Sticky short-circuit flag |
| flag_ol | output | 1 | Sticky open-load flag |
| flag_psf | output | 1 | Sticky supply-fail flag |
| flag_tp | output | 1 | Prewarning status |

## Verification
Some properties are checked on every cycle:
- No leg ever has both gates on.
- Standby and undervoltage mask all gates.
- An overtemperature trip turns the switch off one cycle later.
- A short event sets its flag.
- A clear empties a flag that has no new event.
- Prewarning reaches its status bit.

Other behaviour only the bench scenarios can show:
- A tripped switch stays off across cycles until a reload.
- An illegal command releases when a legal one is loaded.
- A short is ignored while shutdown is disarmed.
- An open-load flag on a switch that is off is ignored.
- A set event and a clear in the same cycle resolve in favour of the set.
- The gates return after undervoltage or standby without a reload.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef struct packed {
    logic tp;
    logic psf;
    logic ol;
    logic sc;
  } hbg_flags_t;

  // gate enable of one switch: own command, partner not commanded, not tripped, stage allowed
  function automatic logic leg_gate(input logic want, input logic partner,
                                    input logic tripped, input logic allow);
    return want & ~partner & ~tripped & allow;
  endfunction

  // next value of a per-switch trip latch
  function automatic logic trip_next(input logic tripped, input logic rearm,
                                     input logic on, input logic hot,
                                     input logic shorted, input logic ocs);
    if (rearm) return 1'b0;
    return tripped | (on & (hot | (shorted & ocs)));
  endfunction

  // sticky flag update: a set event wins over a clear
  function automatic logic sticky_next(input logic cur, input logic set_evt,
                                       input logic clr);
    return set_evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/hbg_leg.sv
module hbg_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cmd_hi_in,
  input  logic cmd_lo_in,
  input  logic ocs_en,
  input  logic allow,
  input  logic sc_hi,
  input  logic sc_lo,
  input  logic ot_hi,
  input  logic ot_lo,
  input  logic ol_hi,
  input  logic ol_lo,
  output logic gate_hi,
  output logic gate_lo,
  output logic sc_evt,
  output logic ol_evt
);
  logic want_hi_q, want_lo_q;
  logic trip_hi_q, trip_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_hi_q <= 1'b0;
      want_lo_q <= 1'b0;
    end else if (load) begin
      want_hi_q <= cmd_hi_in;
      want_lo_q <= cmd_lo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_hi_q <= 1'b0;
      trip_lo_q <= 1'b0;
    end else begin
      trip_hi_q <= hbg_pkg::trip_next(trip_hi_q, load, gate_hi, ot_hi, sc_hi, ocs_en);
      trip_lo_q <= hbg_pkg::trip_next(trip_lo_q, load, gate_lo, ot_lo, sc_lo, ocs_en);
    end
  end

  assign gate_hi = hbg_pkg::leg_gate(want_hi_q, want_lo_q, trip_hi_q, allow);
  assign gate_lo = hbg_pkg::leg_gate(want_lo_q, want_hi_q, trip_lo_q, allow);

  assign sc_evt = ocs_en & ((gate_hi & sc_hi) | (gate_lo & sc_lo));
  assign ol_evt = (gate_hi & ol_hi) | (gate_lo & ol_lo);

  // R3: never both switches of a leg
  p_no_shoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R6: overtemperature on a conducting switch removes it next cycle
  p_ot_trip_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && ot_hi && !load) |=> !gate_hi);
  p_ot_trip_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && ot_lo && !load) |=> !gate_lo);

endmodule

// File: rtl/hbg_flags.sv
module hbg_flags (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sc_any,
  input  logic               ol_any,
  input  logic               uv,
  input  logic               prewarn,
  output hbg_pkg::hbg_flags_t flags
);
  hbg_pkg::hbg_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q.sc  <= hbg_pkg::sticky_next(flags_q.sc,  sc_any, clr);
      flags_q.ol  <= hbg_pkg::sticky_next(flags_q.ol,  ol_any, clr);
      flags_q.psf <= hbg_pkg::sticky_next(flags_q.psf, uv,     clr);
      flags_q.tp  <= prewarn;
    end
  end

  assign flags = flags_q;

  // R4: a short event always lands in the flag
  p_sc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_any |=> flags_q.sc);
  // R12: clear without a new event empties the flag
  p_clr_sc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sc_any) |=> !flags_q.sc);
  p_clr_psf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !uv) |=> !flags_q.psf);
  // R10: undervoltage recorded
  p_psf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> flags_q.psf);
  // R13: prewarning reaches its status bit
  p_tp_r13: assert property (@(posedge clk) disable iff (!rst_n)
    prewarn |=> flags_q.tp);

endmodule

// File: rtl/hb_guard.sv
module hb_guard #(
  parameter int NLEG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_load,
  input  logic [NLEG-1:0] cmd_hi,
  input  logic [NLEG-1:0] cmd_lo,
  input  logic            ocs_en,
  input  logic            clr_stat,
  input  logic [NLEG-1:0] sc_hi,
  input  logic [NLEG-1:0] sc_lo,
  input  logic [NLEG-1:0] ol_hi,
  input  logic [NLEG-1:0] ol_lo,
  input  logic [NLEG-1:0] ot_hi,
  input  logic [NLEG-1:0] ot_lo,
  input  logic            prewarn,
  input  logic            uv,
  input  logic            inh_n,
  output logic [NLEG-1:0] gate_hi,
  output logic [NLEG-1:0] gate_lo,
  output logic [NLEG-1:0] stat_hi,
  output logic [NLEG-1:0] stat_lo,
  output logic            flag_sc,
  output logic            flag_ol,
  output logic            flag_psf,
  output logic            flag_tp
);
  logic                stage_allow;
  logic [NLEG-1:0]     leg_sc_evt;
  logic [NLEG-1:0]     leg_ol_evt;
  hbg_pkg::hbg_flags_t flags;

  assign stage_allow = inh_n & ~uv;

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    hbg_leg u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cmd_load),
      .cmd_hi_in (cmd_hi[i]),
      .cmd_lo_in (cmd_lo[i]),
      .ocs_en    (ocs_en),
      .allow     (stage_allow),
      .sc_hi     (sc_hi[i]),
      .sc_lo     (sc_lo[i]),
      .ot_hi     (ot_hi[i]),
      .ot_lo     (ot_lo[i]),
      .ol_hi     (ol_hi[i]),
      .ol_lo     (ol_lo[i]),
      .gate_hi   (gate_hi[i]),
      .gate_lo   (gate_lo[i]),
      .sc_evt    (leg_sc_evt[i]),
      .ol_evt    (leg_ol_evt[i])
    );
  end

  hbg_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_stat),
    .sc_any  (|leg_sc_evt),
    .ol_any  (|leg_ol_evt),
    .uv      (uv),
    .prewarn (prewarn),
    .flags   (flags)
  );

  assign stat_hi  = gate_hi;
  assign stat_lo  = gate_lo;
  assign flag_sc  = flags.sc;
  assign flag_ol  = flags.ol;
  assign flag_psf = flags.psf;
  assign flag_tp  = flags.tp;

  // R11: standby masks every gate
  p_standby_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |-> (gate_hi == '0 && gate_lo == '0));
  // R10: undervoltage masks every gate
  p_uv_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/hb_guard_bench.sv
module hb_guard_bench;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(P/2) clk = ~clk;

  logic       cmd_load = 0, ocs_en = 1, clr_stat = 0, prewarn = 0, uv = 0, inh_n = 1;
  logic [2:0] cmd_hi = 0, cmd_lo = 0, sc_hi = 0, sc_lo = 0, ol_hi = 0, ol_lo = 0, ot_hi = 0, ot_lo = 0;
  logic [2:0] gate_hi, gate_lo, stat_hi, stat_lo;
  logic       flag_sc, flag_ol, flag_psf, flag_tp;

  // staged stimulus, copied to the pins at a falling edge
  logic       s_load = 0, s_ocs = 1, s_clr = 0, s_tp = 0, s_uv = 0, s_inh = 1;
  logic [2:0] s_chi = 0, s_clo = 0, s_schi = 0, s_sclo = 0, s_olhi = 0, s_ollo = 0, s_othi = 0, s_otlo = 0;

  int checks = 0;
  int errors = 0;
  logic [9:0] q_exp[$];
  string      q_tag[$];

  hb_guard u_hb_guard (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .ocs_en(ocs_en), .clr_stat(clr_stat), .sc_hi(sc_hi), .sc_lo(sc_lo),
    .ol_hi(ol_hi), .ol_lo(ol_lo), .ot_hi(ot_hi), .ot_lo(ot_lo),
    .prewarn(prewarn), .uv(uv), .inh_n(inh_n),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .stat_hi(stat_hi), .stat_lo(stat_lo),
    .flag_sc(flag_sc), .flag_ol(flag_ol), .flag_psf(flag_psf), .flag_tp(flag_tp)
  );

  // driver: expected = {gate_hi, gate_lo, tp, psf, ol, sc} after one cycle with these inputs
  task automatic step(input logic [2:0] ehi, input logic [2:0] elo,
                      input logic [3:0] efl, input string tag);
    @(negedge clk);
    cmd_load = s_load; cmd_hi = s_chi; cmd_lo = s_clo; ocs_en = s_ocs; clr_stat = s_clr;
    sc_hi = s_schi; sc_lo = s_sclo; ol_hi = s_olhi; ol_lo = s_ollo;
    ot_hi = s_othi; ot_lo = s_otlo; prewarn = s_tp; uv = s_uv; inh_n = s_inh;
    q_exp.push_back({ehi, elo, efl});
    q_tag.push_back(tag);
    @(posedge clk);
    s_load = 0;
    s_clr  = 0;
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(P/4);
      if (q_exp.size() > 0) begin
        logic [9:0] e;
        logic [9:0] a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {gate_hi, gate_lo, flag_tp, flag_psf, flag_ol, flag_sc};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: gates/flags actual %b expected %b", t, a, e);
        end
        checks++;
        if ({stat_hi, stat_lo} !== e[9:4]) begin
          errors++;
          $display("FAIL R8: status actual %b expected %b", {stat_hi, stat_lo}, e[9:4]);
        end
      end
    end
  end

  initial begin
    #(P * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(3'b000, 3'b000, 4'b0000, "R1 reset state");
    s_load = 1; s_chi = 3'b001; s_clo = 3'b010;
    step(3'b001, 3'b010, 4'b0000, "R2 load pattern A");
    s_load = 1; s_chi = 3'b101; s_clo = 3'b100;
    step(3'b001, 3'b000, 4'b0000, "R3 illegal leg2 held off");
    s_load = 1; s_chi = 3'b001; s_clo = 3'b100;
    step(3'b001, 3'b100, 4'b0000, "R3 legal command releases");
    s_sclo = 3'b100;
    step(3'b001, 3'b000, 4'b0001, "R4 short trips lo2 and flags");
    s_sclo = 3'b000;
    step(3'b001, 3'b000, 4'b0001, "R7 tripped switch stays off, R4 flag sticky");
    s_clr = 1;
    step(3'b001, 3'b000, 4'b0000, "R12 clear keeps status");
    s_load = 1; s_chi = 3'b001; s_clo = 3'b100;
    step(3'b001, 3'b100, 4'b0000, "R7 reload re-arms");
    s_ocs = 0; s_schi = 3'b001;
    step(3'b001, 3'b100, 4'b0000, "R5 short ignored when disarmed");
    s_schi = 3'b000; s_othi = 3'b001;
    step(3'b000, 3'b100, 4'b0000, "R6 overtemperature trips hi0");
    s_othi = 3'b000; s_ocs = 1;
    step(3'b000, 3'b100, 4'b0000, "R6 hi0 stays off after cooling");
    s_olhi = 3'b001;
    step(3'b000, 3'b100, 4'b0000, "R9 open-load on off switch ignored");
    s_olhi = 3'b000; s_ollo = 3'b100;
    step(3'b000, 3'b100, 4'b0010, "R9 open-load on conducting switch");
    s_ollo = 3'b000; s_uv = 1;
    step(3'b000, 3'b000, 4'b0110, "R10 undervoltage masks gates");
    s_uv = 0;
    step(3'b000, 3'b100, 4'b0110, "R10 gates return after recovery");
    s_inh = 0;
    step(3'b000, 3'b000, 4'b0110, "R11 standby masks gates");
    s_inh = 1;
    step(3'b000, 3'b100, 4'b0110, "R11 command kept through standby");
    s_tp = 1;
    step(3'b000, 3'b100, 4'b1110, "R13 prewarning reported");
    s_clr = 1;
    step(3'b000, 3'b100, 4'b1000, "R12 clear leaves tp and status");
    s_clr = 1; s_ollo = 3'b100;
    step(3'b000, 3'b100, 4'b1010, "R12 set event wins over clear");
    s_ollo = 3'b000; s_tp = 0; s_load = 1; s_chi = 3'b110; s_clo = 3'b001;
    step(3'b110, 3'b001, 4'b0010, "R2 load pattern B, R13 tp drops");
    repeat (2) @(posedge clk);
    #(P/2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule